// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits beside a processor core and arbitrates among 256 numbered interrupt vectors. It keeps three 256-bit sets: requested vectors, in-service vectors and the trigger type last recorded for each vector. It also holds a task priority byte and a 9-bit spurious register. Bit 8 of the spurious register enables the controller in software, and its low byte is the vector handed back when no real vector can be given. From these it derives a processor priority and drives one interrupt-pending line.

Priority is judged on 16 classes, taken from the upper nibble of the vector number. Within a set, a higher vector number means higher priority. The core acknowledges to obtain a vector. The acknowledge either moves the top requested vector into service or returns the spurious vector. The core signals end of interrupt to retire the top in-service vector.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all three vector sets and the task priority are zero, the spurious register reads 0x0FF, the processor priority reads 0 and the pending line is low.
- R2: A set pulse on vector v sets request bit v. It writes trigger bit v to 1 when the level input is high and to 0 when it is low. The change is visible one cycle after the pulse.
- R3: The processor priority equals the task priority when the task class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it equals that class followed by four zero bits. An empty in-service set counts as class 0.
- R4: The pending line is high only when spurious bit 8 is 1, the request set is not empty, and either the processor priority is 0 or the top requested class is strictly greater than the processor priority class.
- R5: An acknowledge that is granted clears the top request bit and sets the same bit in the in-service set. One cycle after the strobe, it presents that vector on the ack output with the ack-done flag high.
- R6: An acknowledge while the task priority is nonzero and the top requested vector is less than or equal to the task priority returns the spurious low byte. It leaves both sets unchanged.
- R7: An acknowledge with an empty request set, or while spurious bit 8 is 0, returns the spurious low byte and changes no set.
- R8: An end-of-interrupt strobe clears the highest in-service bit. With an empty in-service set it changes nothing.
- R9: A spurious-register write keeps only bits 8:0 of the write data.
- R10: A task priority write stores all 8 bits of the write data.
- R11: When a set pulse and a granted acknowledge name the same vector in one cycle, the vector goes into service and its request bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_valid | input | 1 | Request a vector this cycle |
| set_vector | input | 8 | Vector being requested |
| set_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Acknowledge strobe from the core |
| eoi_req | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task priority write enable |
| tpr_wdata | input | 8 | Task priority write data |
| spur_wr | input | 1 | Spurious register write enable |
| spur_wdata | input | 16 | Spurious register write data |
| ack_done | output | 1 | Acknowledge result valid (one cycle after the strobe) |
| ack_vector | output | 8 | Vector returned by the last acknowledge |
| irq_pending | output | 1 | Interrupt pending to the core |
| tpr | output | 8 | Current task priority |
| spur | output | 9 | Current spurious register |
| ppr | output | 8 | Derived processor priority |
| irr_bits | output | 256 | Request set |
| isr_bits | output | 256 | In-service set |
| tmr_bits | output | 256 | Trigger-type set |

## Verification
The bench sets the task priority exactly equal to a pending vector and checks for a spurious return. A design that compares with strict less-than would grant the vector instead. It places a class-0 vector against a zero processor priority and then against a priority of 0x01. A design that drops the zero-priority escape keeps the line low in the first case, and one that compares full bytes instead of classes raises it in the second. The bench also retires in-service vectors one by one, issues an end-of-interrupt on an empty set, acknowledges with nothing requested, and sets and grants the same vector in one cycle. A wrong pick order, a corrupted in-service set or a lost request would show up at the ports in those cases.

// File: rtl/vpc_pkg.sv
// Shared types for the vectored interrupt priority controller.
// Assumes vectors are at least 4 bits wide, so a 4-bit class field exists.
package vpc_pkg;
    localparam int CLASS_W = 4;

    // Outcome of an acknowledge strobe.
    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_GRANT = 2'd1,
        ACK_SPUR  = 2'd2
    } ack_kind_e;
endpackage

// File: rtl/vpc_top_finder.sv
// Finds the highest-numbered set bit of a wide vector.
// Works in two levels: each group of GRP bits finds its own top bit, then the
// highest non-empty group wins. Assumes N is a multiple of GRP and GRP >= 2.
// When no bit is set, any is 0 and idx is 0.
module vpc_top_finder #(
    parameter int N   = 256,
    parameter int GRP = 16
) (
    input  logic [N-1:0]         bits,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int NG = N / GRP;
    localparam int IW = $clog2(N);
    localparam int GW = $clog2(GRP);

    logic [NG-1:0] g_any;
    logic [GW-1:0] g_idx [NG];

    for (genvar g = 0; g < NG; g++) begin : gen_grp
        logic          loc_any;
        logic [GW-1:0] loc_idx;

        // Top set bit inside one group.
        always_comb begin
            loc_any = |bits[g*GRP +: GRP];
            loc_idx = '0;
            for (int i = 0; i < GRP; i++) begin
                if (bits[g*GRP + i]) loc_idx = GW'(i);
            end
        end

        assign g_any[g] = loc_any;
        assign g_idx[g] = loc_idx;
    end

    // Pick the highest non-empty group and build the full index.
    always_comb begin
        any = |g_any;
        idx = '0;
        for (int g = 0; g < NG; g++) begin
            if (g_any[g]) idx = IW'(g * GRP) + IW'(g_idx[g]);
        end
    end
endmodule

// File: rtl/vpc_vec_regs.sv
// Holds the request, in-service and trigger-type vector sets.
// Assumes the caller grants an acknowledge only on a vector present in the
// request set and retires only a vector present in the in-service set.
// A set pulse wins over a grant clearing the same request bit.
module vpc_vec_regs #(
    parameter int N  = 256,
    parameter int VW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_valid,
    input  logic [VW-1:0] set_vec,
    input  logic          set_level,
    input  logic          take,
    input  logic [VW-1:0] take_vec,
    input  logic          retire,
    input  logic [VW-1:0] retire_vec,
    output logic [N-1:0]  irr,
    output logic [N-1:0]  isr,
    output logic [N-1:0]  tmr
);
    logic [N-1:0] set_mask;
    logic [N-1:0] take_mask;
    logic [N-1:0] retire_mask;

    // One-hot masks for each event this cycle.
    always_comb begin
        set_mask    = set_valid ? (N'(1) << set_vec)    : '0;
        take_mask   = take      ? (N'(1) << take_vec)   : '0;
        retire_mask = retire    ? (N'(1) << retire_vec) : '0;
    end

    // Request and in-service set update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
        end else begin
            irr <= (irr & ~take_mask) | set_mask;
            isr <= (isr & ~retire_mask) | take_mask;
        end
    end

    // Trigger-type record for each set pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr <= '0;
        end else if (set_valid) begin
            tmr[set_vec] <= set_level;
        end
    end

    assert_set_records_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> (irr[$past(set_vec)] && tmr[$past(set_vec)] == $past(set_level)));

    assert_grant_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> isr[$past(take_vec)]);

    assert_retire_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !(take && take_vec == retire_vec)) |=> !isr[$past(retire_vec)]);

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_valid && !take && !retire) |=> ($stable(irr) && $stable(isr)));
endmodule

// File: rtl/vpc_prio_eval.sv
// Derives the processor priority and the pending line from the task
// priority and the top entries of the request and in-service sets.
// Purely combinational; clk and rst_n only clock its assertions.
// Assumes the top indices are 0 when their set is empty.
module vpc_prio_eval #(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_en,
    input  logic [VW-1:0] tpr,
    input  logic          irr_any,
    input  logic [VW-1:0] irr_top,
    input  logic          isr_any,
    input  logic [VW-1:0] isr_top,
    output logic [VW-1:0] ppr,
    output logic          pending,
    output logic          ack_block
);
    import vpc_pkg::*;

    localparam int LOW_W = VW - CLASS_W;

    logic [CLASS_W-1:0] tpr_cls;
    logic [CLASS_W-1:0] isr_cls;
    logic [CLASS_W-1:0] irr_cls;
    logic [CLASS_W-1:0] ppr_cls;

    // Class fields of the inputs; an empty in-service set is class 0.
    always_comb begin
        tpr_cls = tpr[VW-1 -: CLASS_W];
        isr_cls = isr_any ? isr_top[VW-1 -: CLASS_W] : '0;
        irr_cls = irr_top[VW-1 -: CLASS_W];
    end

    // Processor priority: task priority or in-service class, whichever is higher.
    always_comb begin
        if (tpr_cls >= isr_cls) ppr = tpr;
        else                    ppr = {isr_cls, {LOW_W{1'b0}}};
        ppr_cls = ppr[VW-1 -: CLASS_W];
    end

    // Pending line and the acknowledge block against the task priority.
    always_comb begin
        pending   = sw_en && irr_any && ((ppr == '0) || (irr_cls > ppr_cls));
        ack_block = (tpr != '0) && (irr_top <= tpr);
    end

    assert_ppr_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ppr[VW-1 -: CLASS_W] >= tpr[VW-1 -: CLASS_W]) &&
        (!isr_any || ppr[VW-1 -: CLASS_W] >= isr_top[VW-1 -: CLASS_W]));

    assert_pending_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (sw_en && irr_any));
endmodule

// File: rtl/vec_prio_ctrl.sv
// Top of the vectored interrupt priority controller.
// Holds the task priority and spurious registers, decides each acknowledge,
// and ties the vector sets to the priority evaluation.
// Assumes one acknowledge and one end-of-interrupt strobe at most per cycle;
// both act on the state present before the clock edge.
module vec_prio_ctrl #(
    parameter int NUM_VEC = 256,
    parameter int GRP     = 16,
    parameter int VW      = $clog2(NUM_VEC),
    parameter int SPUR_W  = VW + 1,
    parameter int WDATA_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_valid,
    input  logic [VW-1:0]      set_vector,
    input  logic               set_level,
    input  logic               ack_req,
    input  logic               eoi_req,
    input  logic               tpr_wr,
    input  logic [VW-1:0]      tpr_wdata,
    input  logic               spur_wr,
    input  logic [WDATA_W-1:0] spur_wdata,
    output logic               ack_done,
    output logic [VW-1:0]      ack_vector,
    output logic               irq_pending,
    output logic [VW-1:0]      tpr,
    output logic [SPUR_W-1:0]  spur,
    output logic [VW-1:0]      ppr,
    output logic [NUM_VEC-1:0] irr_bits,
    output logic [NUM_VEC-1:0] isr_bits,
    output logic [NUM_VEC-1:0] tmr_bits
);
    import vpc_pkg::*;

    localparam logic [SPUR_W-1:0] SPUR_RESET = SPUR_W'((1 << VW) - 1);

    logic          irr_any, isr_any;
    logic [VW-1:0] irr_top, isr_top;
    logic          sw_en;
    logic          ack_block;
    logic          eoi_do;
    ack_kind_e     ack_kind;

    assign sw_en = spur[SPUR_W-1];

    // Classify the acknowledge strobe.
    always_comb begin
        if (!ack_req)                            ack_kind = ACK_IDLE;
        else if (!sw_en || !irr_any || ack_block) ack_kind = ACK_SPUR;
        else                                     ack_kind = ACK_GRANT;
        eoi_do = eoi_req && isr_any;
    end

    // Task priority and spurious register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr  <= '0;
            spur <= SPUR_RESET;
        end else begin
            if (tpr_wr)  tpr  <= tpr_wdata;
            if (spur_wr) spur <= spur_wdata[SPUR_W-1:0];
        end
    end

    // Registered acknowledge result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_done   <= 1'b0;
            ack_vector <= '0;
        end else begin
            ack_done <= (ack_kind != ACK_IDLE);
            if (ack_kind == ACK_GRANT)     ack_vector <= irr_top;
            else if (ack_kind == ACK_SPUR) ack_vector <= spur[VW-1:0];
        end
    end

    vpc_top_finder #(.N(NUM_VEC), .GRP(GRP)) u_irr_find (
        .bits (irr_bits),
        .any  (irr_any),
        .idx  (irr_top)
    );

    vpc_top_finder #(.N(NUM_VEC), .GRP(GRP)) u_isr_find (
        .bits (isr_bits),
        .any  (isr_any),
        .idx  (isr_top)
    );

    vpc_vec_regs #(.N(NUM_VEC), .VW(VW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_valid  (set_valid),
        .set_vec    (set_vector),
        .set_level  (set_level),
        .take       (ack_kind == ACK_GRANT),
        .take_vec   (irr_top),
        .retire     (eoi_do),
        .retire_vec (isr_top),
        .irr        (irr_bits),
        .isr        (isr_bits),
        .tmr        (tmr_bits)
    );

    vpc_prio_eval #(.VW(VW)) u_eval (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_en     (sw_en),
        .tpr       (tpr),
        .irr_any   (irr_any),
        .irr_top   (irr_top),
        .isr_any   (isr_any),
        .isr_top   (isr_top),
        .ppr       (ppr),
        .pending   (irq_pending),
        .ack_block (ack_block)
    );

    assert_spur_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        spur_wr |=> (spur == $past(spur_wdata[SPUR_W-1:0])));

    assert_tpr_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tpr_wr |=> (tpr == $past(tpr_wdata)));

    assert_spur_return_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && (!sw_en || !irr_any || ack_block)) |=>
            (ack_done && ack_vector == $past(spur[VW-1:0])));

    assert_eoi_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !isr_any && !ack_req) |=> $stable(isr_bits));
endmodule

// File: tb/sim_vec_prio_ctrl.sv
`timescale 1ns/1ps
// Directed bench for vec_prio_ctrl: one task per scenario, each checking its results.
module sim_vec_prio_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         set_valid = 1'b0;
    logic [7:0]   set_vector = '0;
    logic         set_level = 1'b0;
    logic         ack_req = 1'b0;
    logic         eoi_req = 1'b0;
    logic         tpr_wr = 1'b0;
    logic [7:0]   tpr_wdata = '0;
    logic         spur_wr = 1'b0;
    logic [15:0]  spur_wdata = '0;
    logic         ack_done;
    logic [7:0]   ack_vector;
    logic         irq_pending;
    logic [7:0]   tpr;
    logic [8:0]   spur;
    logic [7:0]   ppr;
    logic [255:0] irr_bits, isr_bits, tmr_bits;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;
    logic [255:0] exp_irr = '0;
    logic [255:0] exp_isr = '0;

    always #10 clk = ~clk;

    vec_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .set_valid(set_valid), .set_vector(set_vector), .set_level(set_level),
        .ack_req(ack_req), .eoi_req(eoi_req),
        .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata),
        .spur_wr(spur_wr), .spur_wdata(spur_wdata),
        .ack_done(ack_done), .ack_vector(ack_vector), .irq_pending(irq_pending),
        .tpr(tpr), .spur(spur), .ppr(ppr),
        .irr_bits(irr_bits), .isr_bits(isr_bits), .tmr_bits(tmr_bits)
    );

    function automatic logic [255:0] one(input int v);
        return 256'(1) << v;
    endfunction

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic sets_ok(input string tag);
        check({tag, " irr"}, irr_bits, exp_irr);
        check({tag, " isr"}, isr_bits, exp_isr);
    endtask

    task automatic do_set(input int v, input logic lvl);
        set_valid = 1'b1; set_vector = 8'(v); set_level = lvl;
        @(negedge clk);
        set_valid = 1'b0;
        exp_irr |= one(v);
    endtask

    task automatic do_ack();
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    task automatic do_eoi();
        eoi_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
    endtask

    task automatic wr_tpr(input logic [7:0] d);
        tpr_wr = 1'b1; tpr_wdata = d;
        @(negedge clk);
        tpr_wr = 1'b0;
    endtask

    task automatic wr_spur(input logic [15:0] d);
        spur_wr = 1'b1; spur_wdata = d;
        @(negedge clk);
        spur_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 irr", irr_bits, '0);
        check("R1 isr", isr_bits, '0);
        check("R1 tmr", tmr_bits, '0);
        check("R1 tpr", 256'(tpr), 256'h0);
        check("R1 spur", 256'(spur), 256'h0FF);
        check("R1 ppr", 256'(ppr), 256'h0);
        check("R1 pending", 256'(irq_pending), 256'h0);
    endtask

    task automatic t_disabled();
        do_set(8'h40, 1'b0);
        check("R2 irr after set", irr_bits, exp_irr);
        check("R4 pending low while disabled", 256'(irq_pending), 256'h0);
        do_ack();
        check("R7 ack disabled done", 256'(ack_done), 256'h1);
        check("R7 ack disabled vector", 256'(ack_vector), 256'hFF);
        sets_ok("R7 disabled ack no change");
    endtask

    task automatic t_enable();
        wr_spur(16'hFE3C);
        check("R9 spur masked", 256'(spur), 256'h03C);
        check("R4 pending low bit8 clear", 256'(irq_pending), 256'h0);
        wr_spur(16'h713A);
        check("R9 spur enable", 256'(spur), 256'h13A);
        check("R4 pending after enable", 256'(irq_pending), 256'h1);
    endtask

    task automatic t_trigger();
        do_set(8'h81, 1'b1);
        check("R2 tmr level", 256'(tmr_bits[8'h81]), 256'h1);
        check("R2 irr two", irr_bits, exp_irr);
        do_set(8'h81, 1'b0);
        check("R2 tmr edge", 256'(tmr_bits[8'h81]), 256'h0);
    endtask

    task automatic t_ack_take();
        do_ack();
        exp_irr &= ~one(8'h81); exp_isr |= one(8'h81);
        check("R5 ack vector", 256'(ack_vector), 256'h81);
        check("R5 ack done", 256'(ack_done), 256'h1);
        sets_ok("R5 move");
        check("R3 ppr from isr", 256'(ppr), 256'h80);
        check("R4 lower class blocked", 256'(irq_pending), 256'h0);
        @(negedge clk);
        check("R5 ack done one cycle", 256'(ack_done), 256'h0);
    endtask

    task automatic t_tpr();
        wr_tpr(8'h95);
        check("R10 tpr", 256'(tpr), 256'h95);
        check("R3 ppr from tpr", 256'(ppr), 256'h95);
        do_set(8'hA0, 1'b0);
        check("R4 higher class pends", 256'(irq_pending), 256'h1);
        wr_tpr(8'hA3);
        check("R3 ppr tpr A3", 256'(ppr), 256'hA3);
        check("R4 equal class no pend", 256'(irq_pending), 256'h0);
        do_ack();
        check("R6 blocked vector", 256'(ack_vector), 256'h3A);
        sets_ok("R6 blocked no change");
        wr_tpr(8'hA0);
        do_ack();
        check("R6 equal tpr blocked", 256'(ack_vector), 256'h3A);
        sets_ok("R6 equal no change");
        wr_tpr(8'h00);
        check("R3 ppr back to isr", 256'(ppr), 256'h80);
        check("R4 pend A over 8", 256'(irq_pending), 256'h1);
        do_ack();
        exp_irr &= ~one(8'hA0); exp_isr |= one(8'hA0);
        check("R5 ack A0", 256'(ack_vector), 256'hA0);
        sets_ok("R5 nested");
        check("R3 ppr A0", 256'(ppr), 256'hA0);
    endtask

    task automatic t_eoi();
        do_eoi();
        exp_isr &= ~one(8'hA0);
        sets_ok("R8 eoi top");
        check("R3 ppr after eoi", 256'(ppr), 256'h80);
        do_eoi();
        exp_isr &= ~one(8'h81);
        sets_ok("R8 eoi second");
        check("R3 ppr empty isr", 256'(ppr), 256'h00);
        check("R4 pend ppr zero", 256'(irq_pending), 256'h1);
        do_eoi();
        sets_ok("R8 eoi empty no change");
    endtask

    task automatic t_empty_ack();
        do_ack();
        exp_irr &= ~one(8'h40); exp_isr |= one(8'h40);
        check("R5 ack 40", 256'(ack_vector), 256'h40);
        do_ack();
        check("R7 empty ack vector", 256'(ack_vector), 256'h3A);
        sets_ok("R7 empty ack no change");
        do_eoi();
        exp_isr = '0;
        sets_ok("R8 clean");
    endtask

    task automatic t_collide();
        do_set(8'h55, 1'b0);
        set_valid = 1'b1; set_vector = 8'h55; set_level = 1'b0;
        ack_req = 1'b1;
        @(negedge clk);
        set_valid = 1'b0; ack_req = 1'b0;
        exp_isr |= one(8'h55);
        check("R11 ack vector", 256'(ack_vector), 256'h55);
        sets_ok("R11 request kept");
        do_eoi();
        do_ack();
        do_eoi();
        exp_irr = '0; exp_isr = '0;
        sets_ok("R11 drained");
    endtask

    task automatic t_class0();
        do_set(8'h05, 1'b0);
        check("R4 class0 pends at ppr 0", 256'(irq_pending), 256'h1);
        wr_tpr(8'h01);
        check("R3 ppr 01", 256'(ppr), 256'h01);
        check("R4 class0 blocked at ppr 01", 256'(irq_pending), 256'h0);
        do_ack();
        exp_irr = '0; exp_isr = one(8'h05);
        check("R6 vector above tpr granted", 256'(ack_vector), 256'h05);
        sets_ok("R5 class0 move");
        do_eoi();
        exp_isr = '0;
    endtask

    task automatic t_disable();
        do_set(8'h90, 1'b1);
        check("R4 pend 90", 256'(irq_pending), 256'h1);
        wr_spur(16'h003A);
        check("R4 disabled drops pend", 256'(irq_pending), 256'h0);
        sets_ok("R9 disable keeps sets");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_enable();
        t_trigger();
        t_ack_take();
        t_tpr();
        t_eoi();
        t_empty_ack();
        t_collide();
        t_class0();
        t_disable();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule